// File: doc/BRIEF.md
# NAND Sector ECC Result Register Interface

This block is the software-facing side of a NAND sector error-correction engine. It watches the byte strobe on the NAND data port. Once a full sector and the 13 check bytes stored behind it have gone past, it raises a code-ready flag. It then holds the engine's 104-bit result and its detected-error count where a 32-bit register bus can read them. The syndrome and error-locator mathematics sit outside this block. Their result and error count arrive on two input buses and are captured at the moment the flag rises.

Software starts a sector by writing the control register twice: first with the enable bit low, then with it high. It then moves the sector data and the stored check bytes through the data port, one strobe per byte. While it waits, it polls the ready flag in the status register. When the flag is set, it reads result bytes 0 to 11 from three result registers and byte 12 and the error count from the status register. A step-length bit in the control register picks a 512-byte step (bit clear) or a 256-byte step (bit set).

Top module: `ecc_result_regs`

## Requirements
- R1: After reset, every register (control at word 0, status at word 1, results at words 2, 3 and 4) reads as zero.
- R2: A control write with bit 0 set while enable is currently clear restarts accumulation. It clears the byte count, the ready flag, the captured result and the error count.
- R3: A byte is counted only on a clock where enable is set and `data_strobe` is high. Idle cycles and strobes while disabled advance nothing, and the ready flag stays clear while the engine is disabled.
- R4: With control bit 1 clear, status bit 0 (ready) is still clear on the cycle in which the 525th byte is counted. It sets on the next clock edge.
- R5: With control bit 1 set, the step is 256 bytes and ready sets one cycle after the 269th byte is counted. A stream of 268 bytes never sets it.
- R6: When ready sets, the engine result is captured. Result byte k (bits 8k+7:8k) appears little-endian in word 2 + k/4, at bits 8*(k%4)+7:8*(k%4), for k = 0 to 11. Byte 12 appears in status bits [23:16], and the error count appears in status bits [13:10].
- R7: Once ready is set, further strobes and changes on the engine inputs leave the ready flag and every captured field unchanged.
- R8: A control write with bit 0 set while enable is already set does not restart. The ready flag and the captured result stay as they were.
- R9: Clearing enable leaves the ready flag and the captured result readable and unchanged until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, qualified by `bus_sel` |
| bus_addr | input | 3 | Word index: 0 control, 1 status, 2 to 4 result |
| bus_wdata | input | 32 | Write data; control bit 0 is enable, bit 1 is the 256-byte step |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| data_strobe | input | 1 | One pulse per byte moved on the NAND data port |
| eng_result | input | 104 | Result bytes from the correction engine, byte 0 in the low bits |
| eng_errs | input | 4 | Detected error count from the correction engine |

## Verification
The bench targets the exact ready boundary in both step lengths: one byte short, exactly enough, and an overrun. A counter that is off by one, or that compares against the wrong length, would flag one cycle early or never flag at all. Idle cycles placed inside the stream catch a counter that advances without the strobe. A second enable write on an already enabled engine catches a design that restarts on any write of the bit instead of on its low-to-high change, because that design would wipe the result. After ready, the engine inputs are changed and the registers read again. A design that reads the engine through combinationally, or that keeps capturing after ready, would then show the new values.

// File: rtl/ecc_result_regs.sv
module ecc_result_regs #(
  parameter int STEP_FULL  = 512,
  parameter int STEP_HALF  = 256,
  parameter int CODE_BYTES = 13,
  parameter int ERRW       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_we,
  input  logic [2:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    data_strobe,
  input  logic [8*CODE_BYTES-1:0] eng_result,
  input  logic [ERRW-1:0]         eng_errs
);
  localparam int RW = 8 * CODE_BYTES;
  localparam int CW = $clog2(STEP_FULL + CODE_BYTES + 1);

  logic          en_q, half_q, ready_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] res_q;
  logic [ERRW-1:0] errs_q;

  wire ctrl_wr = bus_sel && bus_we && (bus_addr == 3'd0);
  wire restart = ctrl_wr && bus_wdata[0] && !en_q;
  wire [CW-1:0] target = half_q ? CW'(STEP_HALF + CODE_BYTES) : CW'(STEP_FULL + CODE_BYTES);
  wire counting = en_q && data_strobe && (cnt_q < target);
  wire capture  = en_q && !ready_q && (cnt_q == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      half_q  <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
      res_q   <= '0;
      errs_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= bus_wdata[0];
        half_q <= bus_wdata[1];
      end
      if (restart) begin
        cnt_q   <= '0;
        ready_q <= 1'b0;
        res_q   <= '0;
        errs_q  <= '0;
      end else begin
        if (counting) cnt_q <= cnt_q + 1'b1;
        if (capture) begin
          ready_q <= 1'b1;
          res_q   <= eng_result;
          errs_q  <= eng_errs;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: begin
        bus_rdata[0] = en_q;
        bus_rdata[1] = half_q;
      end
      3'd1: begin
        bus_rdata[0]          = ready_q;
        bus_rdata[10 +: ERRW] = errs_q;
        bus_rdata[23:16]      = res_q[96 +: 8];
      end
      3'd2: bus_rdata = res_q[0  +: 32];
      3'd3: bus_rdata = res_q[32 +: 32];
      3'd4: bus_rdata = res_q[64 +: 32];
      default: bus_rdata = '0;
    endcase
  end
endmodule

module ecc_result_regs_chk #(
  parameter int CW = 10,
  parameter int RW = 104
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          en_q,
  input logic          ready_q,
  input logic          data_strobe,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] target,
  input logic [RW-1:0] res_q,
  input logic [RW-1:0] eng_result
);
  p_restart_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!ready_q && cnt_q == '0 && res_q == '0));

  p_no_count_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !restart) |=> $stable(cnt_q));

  p_no_count_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_strobe && !restart) |=> $stable(cnt_q));

  p_ready_after_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(cnt_q) == $past(target)));

  p_capture_engine_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> (res_q == $past(eng_result)));

  p_ready_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !restart) |=> (ready_q && $stable(res_q) && $stable(cnt_q)));

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= target || !en_q);
endmodule

bind ecc_result_regs ecc_result_regs_chk #(.CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .en_q(en_q), .ready_q(ready_q),
  .data_strobe(data_strobe), .cnt_q(cnt_q), .target(target), .res_q(res_q),
  .eng_result(eng_result)
);

// File: tb/ecc_result_regs_tb.sv
module ecc_result_regs_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         bus_sel = 0, bus_we = 0;
  logic [2:0]   bus_addr = 0;
  logic [31:0]  bus_wdata = 0;
  logic [31:0]  bus_rdata;
  logic         data_strobe = 0;
  logic [103:0] eng_result = 0;
  logic [3:0]   eng_errs = 0;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ecc_result_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .data_strobe(data_strobe), .eng_result(eng_result), .eng_errs(eng_errs)
  );

  // {half, byte count, expect ready}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 10'd525, 1'b1}, {1'b0, 10'd524, 1'b0}, {1'b1, 10'd269, 1'b1},
    {1'b1, 10'd268, 1'b0}, {1'b0, 10'd600, 1'b1}, {1'b1, 10'd525, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic strobe(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); data_strobe = 1;
      @(negedge clk); data_strobe = 0;
    end
  endtask

  task automatic restart(logic half);
    wr(0, {30'd0, half, 1'b0});
    wr(0, {30'd0, half, 1'b1});
  endtask

  function automatic logic [103:0] pattern(int seed);
    logic [103:0] r;
    for (int k = 0; k < 13; k++) r[8*k +: 8] = 8'(seed * 16 + k + 1);
    return r;
  endfunction

  function automatic logic [31:0] status_exp(logic rdy, logic [103:0] r, logic [3:0] e);
    logic [31:0] s = '0;
    s[0] = rdy; s[13:10] = e; s[23:16] = r[103:96];
    return s;
  endfunction

  task automatic check_all(string req, logic rdy, logic [103:0] r, logic [3:0] e);
    logic [31:0] d;
    rd(1, d); check(req, d, status_exp(rdy, r, e));
    for (int w = 0; w < 3; w++) begin
      rd(3'(2 + w), d);
      check(req, d, r[32*w +: 32]);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [103:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); check("R1", d, 32'd0);
    end
    rst_n = 1;

    // Vector table: R4, R5, R6, R7
    for (int v = 0; v < 6; v++) begin
      logic half, exp_rdy;
      int n;
      {half, n, exp_rdy} = {VEC[v][11], 32'(VEC[v][10:1]), VEC[v][0]};
      r = pattern(v);
      eng_result = r; eng_errs = 4'(v + 3);
      restart(half);
      strobe(n);
      @(negedge clk);
      if (exp_rdy) check_all(half ? "R5/R6" : "R4/R6", 1'b1, r, 4'(v + 3));
      else         check_all(half ? "R5" : "R4", 1'b0, 104'd0, 4'd0);
    end

    // R2: restart clears captured result
    restart(1'b0);
    check_all("R2", 1'b0, 104'd0, 4'd0);

    // R3 + R4: idle gaps do not count, exact cycle of ready
    r = pattern(9); eng_result = r; eng_errs = 4'd7;
    strobe(524);
    repeat (10) @(negedge clk);
    rd(1, d); check("R3", d, 32'd0);
    strobe(1);
    rd(1, d); check("R4", d, 32'd0);
    @(negedge clk);
    rd(1, d); check("R4", d, status_exp(1'b1, r, 4'd7));

    // R7: engine change and extra strobes after ready
    eng_result = pattern(11); eng_errs = 4'd1;
    strobe(5);
    check_all("R7", 1'b1, r, 4'd7);

    // R8: enable written again while set
    wr(0, 32'd1);
    check_all("R8", 1'b1, r, 4'd7);

    // R9: disable keeps result
    wr(0, 32'd0);
    check_all("R9", 1'b1, r, 4'd7);

    // R3: disabled engine does not count
    restart(1'b0);
    wr(0, 32'd0);
    strobe(600);
    @(negedge clk);
    rd(1, d); check("R3", d, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule